// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block lets a synchronous host read from an asynchronous NOR flash that supports fast page reads. The host presents a read request with a valid/ready handshake. Each request carries a byte address and a flag that selects a byte-wide or word-wide read. The controller drives the flash strobes and address lines. It counts clock cycles until the flash data is settled, then returns the data with a one-cycle valid pulse.

A flash page is eight bytes, or four 16-bit words. The controller remembers which page is open, meaning which page sits on the upper address lines while chip-enable stays low. A read that hits the open page waits only the short intra-page count. A read that opens a new page waits the full random-access count. This applies to a read after reset, a read to a different page, a change of access width, and a read after chip-enable was released. Chip-enable is released, and the page forgotten, after a programmable number of idle cycles with no request.

Top module: `pfr_page_reader`

## Requirements
- R1: While reset is asserted and in the first cycle after it: `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, `req_ready` is high and `rsp_valid` is low.
- R2: `fl_we_n` is high in every cycle; the controller never issues a write strobe.
- R3: From the cycle after a request is accepted until its wait ends, `fl_ce_n` and `fl_oe_n` are low and `req_ready` is low. `fl_addr` holds the request's address bits [11:1] and does not change.
- R4: When no page is open, an accepted request produces `rsp_valid` exactly LONG_WAIT+1 cycles after the accepting clock edge. No page is open after reset or after the idle release of chip-enable.
- R5: A request whose address bits [11:3] and access width match the previous request produces `rsp_valid` exactly SHORT_WAIT+1 cycles after acceptance. This holds while chip-enable has stayed low since that request.
- R6: A request whose address bits [11:3] differ from the open page, or whose access width differs from it, waits LONG_WAIT cycles (`rsp_valid` LONG_WAIT+1 cycles after acceptance).
- R7: If no request is accepted during IDLE_CYC consecutive cycles after a response, `fl_ce_n` rises. Counting starts with the cycle in which `rsp_valid` is high. A request accepted within those IDLE_CYC cycles keeps chip-enable low.
- R8: `rsp_valid` is high for exactly one cycle per accepted request. In word mode (`req_bmode`=0), `rsp_data` equals the 16-bit flash word at word address bits [11:1].
- R9: In byte mode (`req_bmode`=1), `fl_byte_n` is low and `fl_am1` equals address bit 0 during the wait. `rsp_data` is {8'h00, `fl_dq[7:0]`}, so the upper data lines are ignored.
- R10: Whenever no wait is in progress, `fl_oe_n` is high. `fl_oe_n` is never low while `fl_ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_addr | input | 12 | Byte address of the read |
| req_bmode | input | 1 | 1 = byte-wide read, 0 = word-wide read |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the read result |
| rsp_data | output | 16 | Read result (byte reads zero-extended) |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low (held high) |
| fl_byte_n | output | 1 | Flash width select, low for byte-wide reads |
| fl_addr | output | 11 | Flash word address |
| fl_am1 | output | 1 | Flash byte-select address line used in byte mode |
| fl_dq | input | 16 | Flash data bus |

## Verification
The open-page record is the controller's only hidden state. Suppose it stays valid past a chip-enable release, or ignores the width flag, or compares too few address bits. The next response then arrives LONG_WAIT-SHORT_WAIT cycles early, visible at `rsp_valid` on that very access. An idle counter that is off by one shows as `fl_ce_n` rising one cycle early or late. It is probed with gaps of exactly IDLE_CYC-1 and IDLE_CYC cycles, and the resulting wait length exposes the same error on the following read. A wrong captured address or width shows as a data mismatch on the same response.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    localparam int FA_W  = 12;              // byte address bits
    localparam int DQ_W  = 16;              // flash data bus width
    localparam int OFS_W = 3;               // byte offset bits inside a page
    localparam int PG_W  = FA_W - OFS_W;    // page number bits

    typedef enum logic [1:0] {
        PS_CLOSED = 2'd0,
        PS_OPEN   = 2'd1,
        PS_WAIT   = 2'd2
    } pfr_state_e;

    typedef struct packed {
        logic            bmode;
        logic [FA_W-1:0] addr;
    } pfr_req_t;

    typedef struct packed {
        logic            bmode;
        logic [PG_W-1:0] page;
    } pfr_tag_t;

    function automatic pfr_tag_t tag_of(pfr_req_t r);
        pfr_tag_t t;
        t.bmode = r.bmode;
        t.page  = r.addr[FA_W-1:OFS_W];
        return t;
    endfunction

    function automatic logic [DQ_W-1:0] fmt_data(logic bmode, logic [DQ_W-1:0] dq);
        return bmode ? {{(DQ_W-8){1'b0}}, dq[7:0]} : dq;
    endfunction

endpackage

// File: rtl/pfr_page_track.sv
module pfr_page_track
    import pfr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     upd,
    input  pfr_tag_t tag_in,
    output logic     hit
);
    pfr_tag_t tag_q;
    logic     vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            vld_q <= 1'b0;
        end else if (upd) begin
            tag_q <= tag_in;
            vld_q <= 1'b1;
        end else if (clr) begin
            vld_q <= 1'b0;
        end
    end

    assign hit = vld_q && (tag_q == tag_in);
endmodule

// File: rtl/pfr_wait_timer.sv
module pfr_wait_timer #(
    parameter int LONG_WAIT  = 7,
    parameter int SHORT_WAIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic use_short,
    output logic done
);
    localparam int CW = $clog2(LONG_WAIT + 1);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_WAIT - 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_WAIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= use_short ? SHORT_M1 : LONG_M1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pfr_idle_timer.sv
module pfr_idle_timer #(
    parameter int IDLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam logic [IW-1:0] LIM_M1 = IW'(IDLE_CYC - 1);

    logic [IW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc && cnt_q != LIM_M1)
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == LIM_M1);
endmodule

// File: rtl/pfr_page_reader.sv
module pfr_page_reader
    import pfr_pkg::*;
#(
    parameter int LONG_WAIT  = 7,
    parameter int SHORT_WAIT = 2,
    parameter int IDLE_CYC   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [FA_W-1:0] req_addr,
    input  logic            req_bmode,
    output logic            rsp_valid,
    output logic [DQ_W-1:0] rsp_data,
    output logic            fl_ce_n,
    output logic            fl_oe_n,
    output logic            fl_we_n,
    output logic            fl_byte_n,
    output logic [FA_W-2:0] fl_addr,
    output logic            fl_am1,
    input  logic [DQ_W-1:0] fl_dq
);
    pfr_state_e      state_q, state_d;
    pfr_req_t        cur_q, req_in;
    logic            accept, hit, wdone, done, at_limit, expire;
    logic            rsp_valid_q;
    logic [DQ_W-1:0] rsp_data_q;

    assign req_in.bmode = req_bmode;
    assign req_in.addr  = req_addr;
    assign req_ready    = (state_q != PS_WAIT);
    assign accept       = req_valid && req_ready;
    assign done         = (state_q == PS_WAIT) && wdone;
    assign expire       = (state_q == PS_OPEN) && at_limit && !accept;

    pfr_page_track u_track (
        .clk    (clk),
        .rst    (rst),
        .clr    (expire),
        .upd    (accept),
        .tag_in (tag_of(req_in)),
        .hit    (hit)
    );

    pfr_wait_timer #(
        .LONG_WAIT  (LONG_WAIT),
        .SHORT_WAIT (SHORT_WAIT)
    ) u_wait (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .use_short (hit),
        .done      (wdone)
    );

    pfr_idle_timer #(
        .IDLE_CYC (IDLE_CYC)
    ) u_idle (
        .clk      (clk),
        .rst      (rst),
        .clr      (done),
        .inc      (state_q == PS_OPEN),
        .at_limit (at_limit)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            PS_CLOSED: if (accept) state_d = PS_WAIT;
            PS_OPEN: begin
                if (accept)      state_d = PS_WAIT;
                else if (expire) state_d = PS_CLOSED;
            end
            PS_WAIT:   if (wdone) state_d = PS_OPEN;
            default:   state_d = PS_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= PS_CLOSED;
            cur_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            state_q     <= state_d;
            rsp_valid_q <= done;
            if (accept)
                cur_q <= req_in;
            if (done)
                rsp_data_q <= fmt_data(cur_q.bmode, fl_dq);
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign fl_ce_n   = (state_q == PS_CLOSED);
    assign fl_oe_n   = (state_q != PS_WAIT);
    assign fl_we_n   = 1'b1;
    assign fl_byte_n = !cur_q.bmode;
    assign fl_addr   = cur_q.addr[FA_W-1:1];
    assign fl_am1    = cur_q.bmode & cur_q.addr[0];
endmodule

// File: rtl/pfr_checker.sv
module pfr_checker
    import pfr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            fl_ce_n,
    input logic            fl_oe_n,
    input logic            fl_we_n,
    input logic [FA_W-2:0] fl_addr
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (fl_ce_n && fl_oe_n && req_ready && !rsp_valid));

    assert_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> fl_we_n);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(fl_addr));

    assert_busy_in_wait_R3: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !req_ready);

    assert_rsp_follows_wait_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!fl_oe_n));

    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_oe_under_ce_R10: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_ce_n);
endmodule

bind pfr_page_reader pfr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n),
    .fl_addr   (fl_addr)
);

// File: tb/sim_pfr_page_reader.sv
`timescale 1ns/1ps
module sim_pfr_page_reader;
    import pfr_pkg::*;

    localparam int LW = 7;
    localparam int SW = 2;
    localparam int IC = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [FA_W-1:0] req_addr = '0;
    logic            req_bmode = 1'b0;
    logic            rsp_valid;
    logic [DQ_W-1:0] rsp_data;
    logic            fl_ce_n, fl_oe_n, fl_we_n, fl_byte_n, fl_am1;
    logic [FA_W-2:0] fl_addr;
    logic [DQ_W-1:0] fl_dq;

    int total = 0;
    int bad   = 0;
    bit exp_open = 1'b0;
    bit exp_bm   = 1'b0;
    logic [PG_W-1:0] exp_pg = '0;

    always #4 clk = ~clk;

    pfr_page_reader #(.LONG_WAIT(LW), .SHORT_WAIT(SW), .IDLE_CYC(IC)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bmode(req_bmode), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n), .fl_byte_n(fl_byte_n), .fl_addr(fl_addr),
        .fl_am1(fl_am1), .fl_dq(fl_dq)
    );

    function automatic logic [15:0] fmem(logic [FA_W-2:0] wa);
        logic [31:0] t;
        t = {{(32-(FA_W-1)){1'b0}}, wa} * 32'h9E37;
        return t[15:0] ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] exp_data(logic [FA_W-1:0] a, bit bm);
        logic [15:0] w;
        w = fmem(a[FA_W-1:1]);
        if (!bm) return w;
        return {8'h00, (a[0] ? w[15:8] : w[7:0])};
    endfunction

    // behavioural flash: upper byte lines carry junk in byte mode
    always_comb begin
        if (!fl_ce_n && !fl_oe_n) begin
            if (fl_byte_n) fl_dq = fmem(fl_addr);
            else           fl_dq = {8'hA5, (fl_am1 ? fmem(fl_addr)[15:8] : fmem(fl_addr)[7:0])};
        end else begin
            fl_dq = 16'hFFFF;
        end
    end

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic do_read(logic [FA_W-1:0] a, bit bm, int gap);
        bit hit;
        int w;
        int n;
        string tag;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            if (g == 0) chk(!rsp_valid, "R8", int'(rsp_valid), 0);
        end
        if (gap >= IC) exp_open = 1'b0;
        chk(fl_ce_n == !exp_open, "R7", int'(fl_ce_n), int'(!exp_open));
        chk(fl_oe_n && fl_we_n, "R10", int'({fl_oe_n, fl_we_n}), 3);
        hit = exp_open && (exp_bm == bm) && (exp_pg == a[FA_W-1:OFS_W]);
        w   = hit ? SW : LW;
        tag = hit ? "R5" : (exp_open ? "R6" : "R4");
        req_valid = 1'b1;
        req_addr  = a;
        req_bmode = bm;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req_valid = 1'b0;
                chk(!fl_ce_n && !fl_oe_n && !req_ready, "R3",
                    int'({fl_ce_n, fl_oe_n, req_ready}), 0);
                chk(fl_we_n, "R2", int'(fl_we_n), 1);
                chk(fl_addr == a[FA_W-1:1], "R3", int'(fl_addr), int'(a[FA_W-1:1]));
                if (bm) chk(!fl_byte_n && fl_am1 == a[0], "R9",
                            int'({fl_byte_n, fl_am1}), int'({1'b0, a[0]}));
                else    chk(fl_byte_n, "R9", int'(fl_byte_n), 1);
            end
            if (rsp_valid || n > LW + 10) break;
        end
        chk(n == w + 1, tag, n, w + 1);
        chk(rsp_data == exp_data(a, bm), bm ? "R9" : "R8",
            int'(rsp_data), int'(exp_data(a, bm)));
        exp_open = 1'b1;
        exp_bm   = bm;
        exp_pg   = a[FA_W-1:OFS_W];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [FA_W-1:0] a;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(fl_ce_n && fl_oe_n && fl_we_n && req_ready && !rsp_valid, "R1",
            int'({fl_ce_n, fl_oe_n, fl_we_n, req_ready, rsp_valid}), 5'b11110);
        @(negedge clk);
        rst = 1'b0;
        chk(fl_ce_n && fl_oe_n && req_ready && !rsp_valid, "R1",
            int'({fl_ce_n, fl_oe_n, req_ready, rsp_valid}), 4'b1110);

        // directed corners
        do_read(12'h120, 1'b0, 0);      // R4 first access, long
        do_read(12'h126, 1'b0, 0);      // R5 same page, short
        do_read(12'h123, 1'b1, 1);      // R6 width change, long
        do_read(12'h121, 1'b1, IC - 1); // R7 boundary: still open, short
        do_read(12'h127, 1'b1, IC);     // R7 timed out: long
        do_read(12'h128, 1'b1, 2);      // R6 next page, long
        do_read(12'h12E, 1'b0, 0);      // R6 width change back
        do_read(12'h12A, 1'b0, 3);      // R5 short

        // constrained random
        for (int i = 0; i < 300; i++) begin
            int sel;
            sel = int'($urandom % 4);
            if (sel < 2)       a = {exp_pg, 3'($urandom)};
            else if (sel == 2) a = FA_W'($urandom);
            else               a = {exp_pg + 1'b1, 3'($urandom)};
            do_read(a, ($urandom % 4) == 0, int'($urandom % (IC + 3)));
        end

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule